// File: doc/BRIEF.md
# Flash Discovery Header Scanner

This block runs once at boot inside a serial NOR flash controller. On a start pulse it reads the self-describing header area of the attached flash through the simple command port of an existing SPI master. It checks the magic signature and the version, then checks that the mandatory first parameter header describes the basic flash parameter table. After that it walks any further parameter headers and keeps the best basic-table header among them.

Two reads are issued at most. The first fetches bytes 0 to 15, which hold the main header and the first parameter header. The second fetches every additional header in one burst starting at byte 16. Each read uses opcode 0x5A, a 3-byte address and 8 dummy clocks, whatever the controller uses for normal reads. Multi-byte fields are assembled little-endian from the byte stream in arrival order.

The result is the chosen table's 24-bit byte pointer, its length in 32-bit words and its minor revision, qualified by `done`. An `err` flag reports a rejected header area.

Top module: `sfdp_hdr_scan`

## Requirements
- R1: After an accepted start, the block requests a read with opcode 0x5A, address 0, dummy count 8 and length 16. It holds `cmd_valid` and the command fields steady until `cmd_ready`.
- R2: If the little-endian 32-bit value in bytes 0..3 is not 0x50444653, or byte 5 (major version) is not 1, the run ends with `err` high and `done` low.
- R3: The header in bytes 8..15 must have ID 0xFF00 (byte 15 high, byte 8 low) and major version 1 (byte 10). Otherwise the run ends with `err` high and `done` low.
- R4: When byte 6 (extra header count N) is 0 and the checks pass, `done` rises after the first read and no second read is requested. The outputs are then: pointer = bytes 12..14 little-endian, length = byte 11, minor = byte 9.
- R5: When N is above 0, a second read is requested with opcode 0x5A, dummy 8, address 16 and length 8*N bytes.
- R6: An extra header replaces the current choice when its ID is 0xFF00, its major is 1 and its minor is higher.
- R7: An extra header with an equal minor replaces the current choice only if its length is strictly greater. A header with a lower minor never replaces it, whatever its length.
- R8: An extra header whose ID is not 0xFF00, or whose major is not 1, is ignored.
- R9: `done` and `err` are never high together. Once one is set, it and the table outputs stay unchanged until the next start.
- R10: A start pulse while `busy` is high is ignored. No extra read is issued and the result is unchanged.
- R11: Synchronous reset returns the block to idle with `busy`, `done`, `err` and `cmd_valid` low, including in the middle of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that begins a discovery |
| busy | output | 1 | Discovery in progress |
| done | output | 1 | Table outputs valid |
| err | output | 1 | Header area rejected |
| cmd_valid | output | 1 | Read request to the SPI master |
| cmd_ready | input | 1 | SPI master accepts the request |
| cmd_opcode | output | 8 | Read opcode |
| cmd_addr | output | 24 | Flash byte address |
| cmd_dummy | output | 4 | Dummy clock count |
| cmd_len | output | 11 | Number of bytes to read |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| tbl_ptr | output | 24 | Chosen table byte pointer |
| tbl_len | output | 8 | Chosen table length in 32-bit words |
| tbl_minor | output | 8 | Chosen table minor revision |

## Verification
The hardest choices to provoke are the two-level tie-break cases. In one, a later header carries the same minor and a longer length. In the other, a header carries a lower minor but a much longer length. Both sit behind a valid main header, and the deciding byte arrives while the byte stream stalls at random. Directed images place these headers at the first and last extra positions. Random images then mix foreign IDs, wrong majors and repeated minors over up to six extra headers, with random gaps on `cmd_ready` and `rx_valid`. A reset issued mid-stream and a second start issued during a run round this out.

// File: rtl/sfdp_scan_pkg.sv
package sfdp_scan_pkg;

    localparam logic [7:0]  OP_DISCOVER = 8'h5A;
    localparam logic [31:0] MAGIC       = 32'h5044_4653;
    localparam logic [15:0] BASIC_ID    = 16'hFF00;
    localparam logic [7:0]  MAJOR_OK    = 8'd1;
    localparam int          DUMMY_CLKS  = 8;
    localparam int          AREA_BYTES  = 16;
    localparam int          EXT_BASE    = 16;
    localparam int          REC_BYTES   = 8;
    localparam int          REC_W       = REC_BYTES * 8;
    localparam int          CNT_FIELD_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ_AREA,
        ST_RX_AREA,
        ST_REQ_EXT,
        ST_RX_EXT
    } scan_state_e;

    // one 8-byte parameter header, byte 0 in the low bits
    typedef struct packed {
        logic [7:0]  id_hi;
        logic [23:0] ptr;
        logic [7:0]  len_dw;
        logic [7:0]  major;
        logic [7:0]  minor;
        logic [7:0]  id_lo;
    } param_hdr_t;

    // 8-byte main header, byte 0 in the low bits
    typedef struct packed {
        logic [7:0]  spare;
        logic [7:0]  extra;
        logic [7:0]  major;
        logic [7:0]  minor;
        logic [31:0] magic;
    } main_hdr_t;

endpackage

// File: rtl/sfdp_rec_shift.sv
module sfdp_rec_shift
    import sfdp_scan_pkg::*;
#(
    parameter int BYTES = REC_BYTES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 byte_valid,
    input  logic [7:0]           byte_in,
    output logic [BYTES*8-1:0]   rec_o,
    output logic                 rec_last
);
    localparam int IDX_W = $clog2(BYTES);

    typedef struct packed {
        logic [BYTES*8-1:0] sh;
        logic [IDX_W-1:0]   idx;
    } shift_t;

    shift_t q, d;

    // newest byte enters at the top, so byte 0 ends at the bottom
    assign rec_o    = {byte_in, q.sh[BYTES*8-1:8]};
    assign rec_last = byte_valid && (q.idx == IDX_W'(BYTES - 1));

    always_comb begin
        d = q;
        if (clr) begin
            d.idx = '0;
        end else if (byte_valid) begin
            d.sh  = rec_o;
            d.idx = q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/sfdp_best_cmp.sv
module sfdp_best_cmp
    import sfdp_scan_pkg::*;
(
    input  param_hdr_t cand,
    input  param_hdr_t cur,
    output logic       take
);
    logic eligible;
    logic newer;
    logic longer;

    always_comb begin
        eligible = ({cand.id_hi, cand.id_lo} == BASIC_ID) && (cand.major == MAJOR_OK);
        newer    = cand.minor > cur.minor;
        longer   = (cand.minor == cur.minor) && (cand.len_dw > cur.len_dw);
        take     = eligible && (newer || longer);
    end
endmodule

// File: rtl/sfdp_hdr_scan.sv
module sfdp_hdr_scan
    import sfdp_scan_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int DUMMY_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [7:0]         cmd_opcode,
    output logic [ADDR_W-1:0]  cmd_addr,
    output logic [DUMMY_W-1:0] cmd_dummy,
    output logic [10:0]        cmd_len,
    input  logic               rx_valid,
    input  logic [7:0]         rx_data,
    output logic [23:0]        tbl_ptr,
    output logic [7:0]         tbl_len,
    output logic [7:0]         tbl_minor
);
    localparam int LEN_W = CNT_FIELD_W + $clog2(REC_BYTES);

    typedef struct packed {
        scan_state_e             st;
        logic [LEN_W-1:0]        cnt;
        logic [CNT_FIELD_W-1:0]  extra;
        logic                    bad;
        logic                    done;
        logic                    err;
        param_hdr_t              best;
    } ctl_t;

    ctl_t q, d;

    logic             cmd_take;
    logic [REC_W-1:0] rec_raw;
    logic             rec_last;
    param_hdr_t       rec_hdr;
    main_hdr_t        rec_main;
    logic             take_new;
    logic [LEN_W-1:0] ext_len;

    assign cmd_take = cmd_valid && cmd_ready;
    assign rec_hdr  = param_hdr_t'(rec_raw);
    assign rec_main = main_hdr_t'(rec_raw);
    assign ext_len  = {q.extra, 3'b000};

    sfdp_rec_shift #(.BYTES(REC_BYTES)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .clr       (cmd_take),
        .byte_valid(rx_valid && (q.st == ST_RX_AREA || q.st == ST_RX_EXT)),
        .byte_in   (rx_data),
        .rec_o     (rec_raw),
        .rec_last  (rec_last)
    );

    sfdp_best_cmp u_cmp (
        .cand(rec_hdr),
        .cur (q.best),
        .take(take_new)
    );

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st   = ST_REQ_AREA;
                    d.done = 1'b0;
                    d.err  = 1'b0;
                    d.bad  = 1'b0;
                end
            end
            ST_REQ_AREA: begin
                if (cmd_ready) begin
                    d.st  = ST_RX_AREA;
                    d.cnt = '0;
                end
            end
            ST_RX_AREA: begin
                if (rx_valid) begin
                    d.cnt = q.cnt + 1'b1;
                    if (rec_last && !q.cnt[3]) begin
                        if (rec_main.magic != MAGIC || rec_main.major != MAJOR_OK)
                            d.bad = 1'b1;
                        d.extra = rec_main.extra;
                    end
                    if (rec_last && q.cnt[3]) begin
                        if ({rec_hdr.id_hi, rec_hdr.id_lo} != BASIC_ID ||
                            rec_hdr.major != MAJOR_OK)
                            d.bad = 1'b1;
                        d.best = rec_hdr;
                    end
                    if (q.cnt == LEN_W'(AREA_BYTES - 1)) begin
                        if (d.bad) begin
                            d.st   = ST_IDLE;
                            d.err  = 1'b1;
                            d.best = '0;
                        end else if (d.extra == '0) begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                        end else begin
                            d.st   = ST_REQ_EXT;
                        end
                    end
                end
            end
            ST_REQ_EXT: begin
                if (cmd_ready) begin
                    d.st  = ST_RX_EXT;
                    d.cnt = '0;
                end
            end
            ST_RX_EXT: begin
                if (rx_valid) begin
                    d.cnt = q.cnt + 1'b1;
                    if (rec_last && take_new)
                        d.best = rec_hdr;
                    if (q.cnt == ext_len - 1'b1) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            q.st   <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy       = (q.st != ST_IDLE);
    assign done       = q.done;
    assign err        = q.err;
    assign cmd_valid  = (q.st == ST_REQ_AREA) || (q.st == ST_REQ_EXT);
    assign cmd_opcode = OP_DISCOVER;
    assign cmd_dummy  = DUMMY_W'(DUMMY_CLKS);
    assign cmd_addr   = (q.st == ST_REQ_EXT) ? ADDR_W'(EXT_BASE) : '0;
    assign cmd_len    = (q.st == ST_REQ_EXT) ? 11'(ext_len) : 11'(AREA_BYTES);
    assign tbl_ptr    = q.best.ptr;
    assign tbl_len    = q.best.len_dw;
    assign tbl_minor  = q.best.minor;
endmodule

// File: rtl/sfdp_hdr_scan_chk.sv
module sfdp_hdr_scan_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [7:0]  cmd_opcode,
    input logic [23:0] cmd_addr,
    input logic [3:0]  cmd_dummy,
    input logic [10:0] cmd_len,
    input logic [23:0] tbl_ptr,
    input logic [7:0]  tbl_len,
    input logic [7:0]  tbl_minor
);
    p_cmd_fields_r1: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_opcode == 8'h5A && cmd_dummy == 4'd8));

    p_cmd_hold_r1: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len));

    p_ext_cmd_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_addr != 24'd0 |-> cmd_addr == 24'd16 && cmd_len[2:0] == 3'd0 && cmd_len != 11'd0);

    p_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    p_hold_done_r9: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> done && $stable(tbl_ptr) && $stable(tbl_len) && $stable(tbl_minor));

    p_hold_err_r9: assert property (@(posedge clk) disable iff (rst)
        err && !start |=> err);

    p_busy_clear_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done && !err);

    p_reset_idle_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !busy && !done && !err && !cmd_valid);
endmodule

bind sfdp_hdr_scan sfdp_hdr_scan_chk u_chk (.*);

// File: tb/sfdp_hdr_scan_tb.sv
module sfdp_hdr_scan_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        busy, done, err, cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [7:0]  cmd_opcode;
    logic [23:0] cmd_addr;
    logic [3:0]  cmd_dummy;
    logic [10:0] cmd_len;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic [23:0] tbl_ptr;
    logic [7:0]  tbl_len, tbl_minor;

    always #5 clk = ~clk;

    sfdp_hdr_scan dut_i (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .err(err),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
        .cmd_addr(cmd_addr), .cmd_dummy(cmd_dummy), .cmd_len(cmd_len),
        .rx_valid(rx_valid), .rx_data(rx_data), .tbl_ptr(tbl_ptr),
        .tbl_len(tbl_len), .tbl_minor(tbl_minor)
    );

    logic [7:0] img [0:2047];
    int total = 0;
    int fails = 0;
    bit finished = 0;

    // flash responder state
    int         ncmd;
    logic [7:0] c_op;
    logic [3:0] c_dummy;
    int         c_addr [0:1];
    int         c_len  [0:1];
    bit         streaming = 0;
    int         saddr, srem;

    // expected result
    bit          exp_err;
    logic [23:0] exp_ptr;
    logic [7:0]  exp_len, exp_min;
    int          exp_ncmd, exp_ext;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_img();
        for (int i = 0; i < 2048; i++) img[i] = 8'h00;
    endtask

    task automatic put_main(logic [31:0] sig, logic [7:0] mn, logic [7:0] mj, logic [7:0] n);
        img[0] = sig[7:0]; img[1] = sig[15:8]; img[2] = sig[23:16]; img[3] = sig[31:24];
        img[4] = mn; img[5] = mj; img[6] = n; img[7] = 8'hFF;
    endtask

    task automatic put_hdr(int idx, logic [15:0] id, logic [7:0] mn, logic [7:0] mj,
                           logic [7:0] ln, logic [23:0] p);
        int b;
        b = 8 + 8 * idx;
        img[b]   = id[7:0];  img[b+1] = mn; img[b+2] = mj; img[b+3] = ln;
        img[b+4] = p[7:0];   img[b+5] = p[15:8]; img[b+6] = p[23:16]; img[b+7] = id[15:8];
    endtask

    function automatic void compute_exp();
        int n, b;
        logic [31:0] sig;
        sig = {img[3], img[2], img[1], img[0]};
        exp_err = (sig != 32'h50444653) || (img[5] != 8'd1) ||
                  ({img[15], img[8]} != 16'hFF00) || (img[10] != 8'd1);
        exp_min = img[9];
        exp_len = img[11];
        exp_ptr = {img[14], img[13], img[12]};
        n = int'(img[6]);
        for (int k = 1; k <= n; k++) begin
            b = 8 + 8 * k;
            if ({img[b+7], img[b]} == 16'hFF00 && img[b+2] == 8'd1 &&
                (img[b+1] > exp_min || (img[b+1] == exp_min && img[b+3] > exp_len))) begin
                exp_min = img[b+1];
                exp_len = img[b+3];
                exp_ptr = {img[b+6], img[b+5], img[b+4]};
            end
        end
        exp_ext  = 8 * n;
        exp_ncmd = (exp_err || n == 0) ? 1 : 2;
    endfunction

    // flash model: drives cmd_ready / rx_* on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            cmd_ready = 1'b0;
            rx_valid  = 1'b0;
            if (rst) begin
                streaming = 0;
            end else if (streaming) begin
                if ($urandom % 4 != 0) begin
                    rx_valid = 1'b1;
                    rx_data  = img[saddr];
                    saddr++;
                    srem--;
                    if (srem == 0) streaming = 0;
                end
            end else if (cmd_valid && ($urandom % 3 == 0)) begin
                cmd_ready = 1'b1;
                if (ncmd < 2) begin
                    c_addr[ncmd] = int'(cmd_addr);
                    c_len[ncmd]  = int'(cmd_len);
                end
                if (ncmd == 0) begin
                    c_op    = cmd_opcode;
                    c_dummy = cmd_dummy;
                end
                ncmd++;
                streaming = 1;
                saddr = int'(cmd_addr);
                srem  = int'(cmd_len);
            end
        end
    end

    task automatic pulse_start();
        @(posedge clk); #2 start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
    endtask

    task automatic run_case(string tag, bit dbl);
        int guard;
        compute_exp();
        ncmd = 0;
        pulse_start();
        if (dbl) begin
            repeat (3) @(posedge clk);
            chk({tag, " R10 busy before second start"}, busy, 1'b1);
            #2 start = 1'b1;
            @(posedge clk); #2 start = 1'b0;
        end
        guard = 0;
        @(negedge clk);
        while (!(done || err) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 5000) begin
            fails++;
            total++;
            $display("FAIL %s watchdog: actual busy expected finish", tag);
            return;
        end
        chk({tag, " R2/R3 err"}, err, exp_err);
        chk({tag, " R9 done"}, done, !exp_err);
        chk({tag, " R1 opcode"}, c_op, 8'h5A);
        chk({tag, " R1 dummy"}, c_dummy, 4'd8);
        chk({tag, " R1 addr"}, c_addr[0], 0);
        chk({tag, " R1 len"}, c_len[0], 16);
        chk({tag, " R4/R5/R10 read count"}, ncmd, exp_ncmd);
        if (exp_ncmd == 2) begin
            chk({tag, " R5 ext addr"}, c_addr[1], 16);
            chk({tag, " R5 ext len"}, c_len[1], exp_ext);
        end
        if (!exp_err) begin
            chk({tag, " R6/R7/R8 ptr"}, tbl_ptr, exp_ptr);
            chk({tag, " R6/R7/R8 len"}, tbl_len, exp_len);
            chk({tag, " R6/R7/R8 minor"}, tbl_minor, exp_min);
        end
        repeat (4) @(negedge clk);
        chk({tag, " R9 status held"}, {done, err}, {!exp_err, exp_err});
        if (!exp_err)
            chk({tag, " R9 ptr held"}, tbl_ptr, exp_ptr);
    endtask

    task automatic base_good(int n);
        clear_img();
        put_main(32'h50444653, 8'd6, 8'd1, 8'(n));
        put_hdr(0, 16'hFF00, 8'd5, 8'd1, 8'd16, 24'h000030);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            fails++;
            total++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        ncmd = 0;
        clear_img();
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        chk("R11 reset busy", busy, 1'b0);
        chk("R11 reset done/err", {done, err}, 2'b00);
        chk("R11 reset cmd_valid", cmd_valid, 1'b0);

        // R4 single basic header, little-endian pointer
        base_good(0);
        put_hdr(0, 16'hFF00, 8'd6, 8'd1, 8'd9, 24'hA1B2C3);
        run_case("R4 single", 0);

        // R2 bad signature / bad major
        base_good(2);
        img[2] = 8'h45;
        run_case("R2 bad magic", 0);
        base_good(0);
        img[5] = 8'd2;
        run_case("R2 bad major", 0);

        // R3 bad first header id / major
        base_good(0);
        img[15] = 8'hEF;
        run_case("R3 bad id", 0);
        base_good(0);
        img[10] = 8'd0;
        run_case("R3 bad major", 0);

        // R6 higher minor at last position
        base_good(3);
        put_hdr(1, 16'hFF00, 8'd5, 8'd1, 8'd10, 24'h000100);
        put_hdr(2, 16'hEF01, 8'd9, 8'd1, 8'd40, 24'h000200);
        put_hdr(3, 16'hFF00, 8'd6, 8'd1, 8'd12, 24'h000300);
        run_case("R6 newer", 0);

        // R7 equal minor longer, then equal minor shorter, then lower minor longer
        base_good(3);
        put_hdr(1, 16'hFF00, 8'd5, 8'd1, 8'd20, 24'h000400);
        put_hdr(2, 16'hFF00, 8'd5, 8'd1, 8'd18, 24'h000500);
        put_hdr(3, 16'hFF00, 8'd4, 8'd1, 8'd60, 24'h000600);
        run_case("R7 tie", 0);

        // R8 wrong id and wrong major, both newer
        base_good(2);
        put_hdr(1, 16'hFF01, 8'd9, 8'd1, 8'd30, 24'h000700);
        put_hdr(2, 16'hFF00, 8'd9, 8'd2, 8'd30, 24'h000800);
        run_case("R8 foreign", 0);

        // R10 second start while busy
        base_good(2);
        put_hdr(2, 16'hFF00, 8'd7, 8'd1, 8'd16, 24'h000900);
        run_case("R10 restart", 1);

        // R11 reset in the middle of the stream
        base_good(4);
        ncmd = 0;
        pulse_start();
        while (ncmd == 0) @(posedge clk);
        repeat (6) @(posedge clk);
        #2 rst = 1'b1;
        repeat (2) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        chk("R11 mid-run busy", busy, 1'b0);
        chk("R11 mid-run done/err", {done, err}, 2'b00);
        chk("R11 mid-run cmd_valid", cmd_valid, 1'b0);
        run_case("R11 recovery", 0);

        // random images
        for (int t = 0; t < 40; t++) begin
            int n;
            clear_img();
            n = int'($urandom % 7);
            put_main(($urandom % 10 == 0) ? 32'h50444654 : 32'h50444653, 8'($urandom % 8),
                     ($urandom % 12 == 0) ? 8'd0 : 8'd1, 8'(n));
            for (int k = 0; k <= n; k++)
                put_hdr(k, ($urandom % 5 == 0) ? 16'h0001 : 16'hFF00, 8'($urandom % 4),
                        ($urandom % 6 == 0) ? 8'd3 : 8'd1, 8'(9 + $urandom % 8), 24'($urandom));
            run_case("R6/R7/R8 random", t % 9 == 0);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end
endmodule